// File: doc/BRIEF.md
# Packet Timestamp Capture Slot

This block holds one captured time value for one traffic direction of a precision time protocol datapath. A packet parser outside the block raises a one-cycle match strobe together with the parameter bits and rule bits that the packet hit, and a 16-bit sequence identifier. When the strobe qualifies and the slot is empty, the block stores the free-running 64-bit time counter value present on that clock edge, along with the sequence identifier. It then raises a valid flag. Two instances are used, one for receive and one for transmit. The receive instance is built with the host-route requirement switched on.

Software polls a status word. The valid flag is bit 16 of that word and the sequence identifier is bits 15:0. Software must not read the stored time while the flag is 0. Once the flag is set, software reads the time as a low word and a high word. It then writes a 1 to bit 16 to release the slot. While the slot is full, every later event is dropped, so the first time value stays in the slot until software acknowledges it.

The control logic is a two-state machine. In state SLOT_EMPTY the CAPTURE transition fires on a qualified strobe and moves to SLOT_FULL. Without a qualified strobe the machine stays in SLOT_EMPTY (WAIT). In state SLOT_FULL the RELEASE transition fires on an acknowledge write and moves back to SLOT_EMPTY. Without an acknowledge the machine stays in SLOT_FULL (HOLD), whatever events arrive.

Top module: `ts_capture_slot`

## Requirements
- R1: After reset the registers read as follows: status 0x0, time low 0x0, time high 0x0, parameter mask 0x7FF, rule mask 0x3FFF, enable 0x0 and host route 0x0. Therefore no event can be captured until software configures the block.
- R2: The register map is: address 0 status, 1 time low word, 2 time high word, 3 parameter mask (11 bits), 4 rule mask (14 bits), 5 enable (3 bits), 6 host route (bit 0). A write keeps only the field's low bits, and every read returns zeros above the field.
- R3: A qualified strobe in state SLOT_EMPTY latches the time counter value and the sequence identifier on that clock edge. From the next cycle, status reads as (1<<16) | sequence identifier. The time low word then reads bits 31:0 of the latched value and the time high word reads bits 63:32.
- R4: A strobe that arrives in state SLOT_FULL is ignored. The status word, both time words and the sequence identifier are unchanged.
- R5: A write to status with bit 16 set clears the valid flag and makes the slot ready for a new capture. The stored time and sequence identifier are kept. A write to status with bit 16 clear has no effect.
- R6: A strobe qualifies only if at least one set parameter bit has its parameter mask bit at 0, and at least one set rule bit has its rule mask bit at 0. With either mask all ones, nothing qualifies.
- R7: A strobe qualifies only while the enable register holds 7. Any other value, including 0, blocks capture.
- R8: When HOST_ROUTE_REQ is 1 (the receive instance), a strobe qualifies only while host route bit 0 is 1.
- R9: When an acknowledge write and a strobe coincide in state SLOT_FULL, the slot is released and the strobe is dropped. Status then reads with bit 16 at 0.
- R10: When an acknowledge write and a qualified strobe coincide in state SLOT_EMPTY, the strobe is captured. Status then reads with bit 16 at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Read data for rd_addr, combinational |
| time_now | input | 64 | Free-running time counter value |
| evt_strobe | input | 1 | One-cycle match strobe from the parser |
| evt_param | input | 11 | Parameter bits hit by the packet |
| evt_rule | input | 14 | Rule bits hit by the packet |
| evt_seq | input | 16 | Sequence identifier of the packet |

## Verification
The hardest cases to reach are the two collisions, where an acknowledge write and a strobe land on the same clock edge. They occur once in state SLOT_FULL and once in state SLOT_EMPTY. A dedicated bench task drives the write and the strobe on the same falling edge, so both are seen at one rising edge. The bench first steers the slot into the required state through ordinary captures and releases. Qualification is probed by changing one gate at a time: a single mask bit, the enable value or the host route bit. The status word is read after each strobe to confirm that nothing was latched.

// File: rtl/ts_cap_pkg.sv
package ts_cap_pkg;

    typedef enum logic [0:0] {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_state_e;

    typedef enum logic [2:0] {
        A_STATUS = 3'd0,
        A_TS_LO  = 3'd1,
        A_TS_HI  = 3'd2,
        A_PMASK  = 3'd3,
        A_RMASK  = 3'd4,
        A_ENABLE = 3'd5,
        A_ROUTE  = 3'd6
    } reg_addr_e;

endpackage

// File: rtl/ts_cap_cfg.sv
module ts_cap_cfg
    import ts_cap_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned ADDR_W    = 3,
    parameter int unsigned PARAM_W   = 11,
    parameter int unsigned RULE_W    = 14,
    parameter int unsigned EN_W      = 3,
    parameter int unsigned VALID_BIT = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [PARAM_W-1:0] pmask_q,
    output logic [RULE_W-1:0]  rmask_q,
    output logic [EN_W-1:0]    en_q,
    output logic               route_q,
    output logic               ack_req
);

    logic unused_wr_bits;
    assign unused_wr_bits = ^wr_data;

    // Software acknowledge: a 1 written to the valid bit position of status.
    assign ack_req = wr_en && (wr_addr == ADDR_W'(A_STATUS)) && wr_data[VALID_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pmask_q <= '1;
            rmask_q <= '1;
            en_q    <= '0;
            route_q <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(A_PMASK))  pmask_q <= wr_data[PARAM_W-1:0];
            if (wr_addr == ADDR_W'(A_RMASK))  rmask_q <= wr_data[RULE_W-1:0];
            if (wr_addr == ADDR_W'(A_ENABLE)) en_q    <= wr_data[EN_W-1:0];
            if (wr_addr == ADDR_W'(A_ROUTE))  route_q <= wr_data[0];
        end
    end

    AST_MASK_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(A_PMASK)) |=> (pmask_q == $past(wr_data[PARAM_W-1:0]))) // R2
        else $error("parameter mask write lost");

endmodule

// File: rtl/ts_cap_qual.sv
module ts_cap_qual #(
    parameter int unsigned PARAM_W        = 11,
    parameter int unsigned RULE_W         = 14,
    parameter int unsigned EN_W           = 3,
    parameter bit          HOST_ROUTE_REQ = 1'b1
) (
    input  logic               evt_strobe,
    input  logic [PARAM_W-1:0] evt_param,
    input  logic [RULE_W-1:0]  evt_rule,
    input  logic [PARAM_W-1:0] pmask,
    input  logic [RULE_W-1:0]  rmask,
    input  logic [EN_W-1:0]    en,
    input  logic               route,
    output logic               accept
);

    localparam logic [EN_W-1:0] EN_ON = '1;

    logic param_hit;
    logic rule_hit;
    logic en_ok;
    logic route_ok;

    assign param_hit = |(evt_param & ~pmask);
    assign rule_hit  = |(evt_rule & ~rmask);
    assign en_ok     = (en == EN_ON);

    generate
        if (HOST_ROUTE_REQ) begin : g_route_gate
            assign route_ok = route;
        end else begin : g_route_free
            logic unused_route;
            assign unused_route = route;
            assign route_ok = 1'b1;
        end
    endgenerate

    assign accept = evt_strobe && en_ok && route_ok && param_hit && rule_hit;

endmodule

// File: rtl/ts_cap_slot.sv
module ts_cap_slot
    import ts_cap_pkg::*;
#(
    parameter int unsigned TS_W  = 64,
    parameter int unsigned SEQ_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             ack_req,
    input  logic [TS_W-1:0]  time_now,
    input  logic [SEQ_W-1:0] evt_seq,
    output logic             full,
    output logic [TS_W-1:0]  ts_q,
    output logic [SEQ_W-1:0] seq_q
);

    slot_state_e state_q;
    slot_state_e state_d;
    logic        take;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_EMPTY;
        else        state_q <= state_d;
    end

    // Transitions: CAPTURE (empty->full), RELEASE (full->empty), WAIT, HOLD.
    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        unique case (state_q)
            SLOT_EMPTY: begin
                if (accept) begin
                    state_d = SLOT_FULL;
                    take    = 1'b1;
                end
            end
            SLOT_FULL: begin
                if (ack_req) state_d = SLOT_EMPTY;
            end
            default: state_d = SLOT_EMPTY;
        endcase
    end

    // Outputs and captured data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts_q  <= '0;
            seq_q <= '0;
        end else if (take) begin
            ts_q  <= time_now;
            seq_q <= evt_seq;
        end
    end

    assign full = (state_q == SLOT_FULL);

    AST_CAPTURE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLOT_EMPTY && accept) |=> (full && ts_q == $past(time_now) && seq_q == $past(evt_seq))) // R3
        else $error("capture did not latch");

    AST_FULL_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !ack_req) |=> (full && $stable(ts_q) && $stable(seq_q))) // R4
        else $error("held timestamp changed");

    AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (full && ack_req) |=> (!full && $stable(ts_q))) // R9
        else $error("acknowledge did not release slot");

    AST_FILL_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full) |-> $past(accept)) // R6
        else $error("slot filled without a qualified strobe");

endmodule

// File: rtl/ts_capture_slot.sv
module ts_capture_slot
    import ts_cap_pkg::*;
#(
    parameter int unsigned DATA_W         = 32,
    parameter int unsigned ADDR_W         = 3,
    parameter int unsigned TS_W           = 64,
    parameter int unsigned SEQ_W          = 16,
    parameter int unsigned PARAM_W        = 11,
    parameter int unsigned RULE_W         = 14,
    parameter int unsigned EN_W           = 3,
    parameter bit          HOST_ROUTE_REQ = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    input  logic [TS_W-1:0]    time_now,
    input  logic               evt_strobe,
    input  logic [PARAM_W-1:0] evt_param,
    input  logic [RULE_W-1:0]  evt_rule,
    input  logic [SEQ_W-1:0]   evt_seq
);

    localparam int unsigned VALID_BIT = SEQ_W;
    localparam int unsigned STAT_PAD  = DATA_W - SEQ_W - 1;
    localparam logic [EN_W-1:0] EN_ON = '1;

    logic [PARAM_W-1:0] pmask_q;
    logic [RULE_W-1:0]  rmask_q;
    logic [EN_W-1:0]    en_q;
    logic               route_q;
    logic               ack_req;
    logic               accept;
    logic               full;
    logic [TS_W-1:0]    ts_q;
    logic [SEQ_W-1:0]   seq_q;

    ts_cap_cfg #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PARAM_W(PARAM_W),
        .RULE_W(RULE_W), .EN_W(EN_W), .VALID_BIT(VALID_BIT)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pmask_q(pmask_q), .rmask_q(rmask_q),
        .en_q(en_q), .route_q(route_q), .ack_req(ack_req)
    );

    ts_cap_qual #(
        .PARAM_W(PARAM_W), .RULE_W(RULE_W), .EN_W(EN_W),
        .HOST_ROUTE_REQ(HOST_ROUTE_REQ)
    ) u_qual (
        .evt_strobe(evt_strobe), .evt_param(evt_param), .evt_rule(evt_rule),
        .pmask(pmask_q), .rmask(rmask_q), .en(en_q), .route(route_q),
        .accept(accept)
    );

    ts_cap_slot #(
        .TS_W(TS_W), .SEQ_W(SEQ_W)
    ) u_slot (
        .clk(clk), .rst_n(rst_n), .accept(accept), .ack_req(ack_req),
        .time_now(time_now), .evt_seq(evt_seq), .full(full),
        .ts_q(ts_q), .seq_q(seq_q)
    );

    // Read mux.
    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            ADDR_W'(A_STATUS): rd_data = {{STAT_PAD{1'b0}}, full, seq_q};
            ADDR_W'(A_TS_LO):  rd_data = ts_q[DATA_W-1:0];
            ADDR_W'(A_TS_HI):  rd_data = ts_q[2*DATA_W-1:DATA_W];
            ADDR_W'(A_PMASK):  rd_data = {{(DATA_W-PARAM_W){1'b0}}, pmask_q};
            ADDR_W'(A_RMASK):  rd_data = {{(DATA_W-RULE_W){1'b0}}, rmask_q};
            ADDR_W'(A_ENABLE): rd_data = {{(DATA_W-EN_W){1'b0}}, en_q};
            ADDR_W'(A_ROUTE):  rd_data = {{(DATA_W-1){1'b0}}, route_q};
            default:           rd_data = '0;
        endcase
    end

    AST_DISABLED_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q != EN_ON) |-> !accept) // R7
        else $error("strobe accepted while disabled");

    AST_MASKED_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (pmask_q == '1 || rmask_q == '1) |-> !accept) // R6
        else $error("strobe accepted with a fully masked set");

endmodule

// File: tb/ts_capture_slot_test.sv
module ts_capture_slot_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [63:0] time_now = '0;
    logic        evt_strobe = 1'b0;
    logic [10:0] evt_param = '0;
    logic [13:0] evt_rule = '0;
    logic [15:0] evt_seq = '0;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    ts_capture_slot uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .time_now(time_now), .evt_strobe(evt_strobe), .evt_param(evt_param),
        .evt_rule(evt_rule), .evt_seq(evt_seq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic rd_check(input string req, input logic [2:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic evt(input logic [10:0] p, input logic [13:0] r,
                       input logic [15:0] s, input logic [63:0] t);
        @(negedge clk);
        evt_strobe = 1'b1; evt_param = p; evt_rule = r; evt_seq = s; time_now = t;
        @(negedge clk);
        evt_strobe = 1'b0;
    endtask

    task automatic ack_and_evt(input logic [15:0] s, input logic [63:0] t);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd0; wr_data = 32'h0001_0000;
        evt_strobe = 1'b1; evt_param = 11'h1; evt_rule = 14'h1; evt_seq = s; time_now = t;
        @(negedge clk);
        wr_en = 1'b0; evt_strobe = 1'b0;
    endtask

    task automatic configure_open();
        wr(3'd3, 32'h0);
        wr(3'd4, 32'h0);
        wr(3'd5, 32'h7);
        wr(3'd6, 32'h1);
    endtask

    task automatic t_reset();
        rd_check("R1 status", 3'd0, 32'h0);
        rd_check("R1 ts_lo", 3'd1, 32'h0);
        rd_check("R1 ts_hi", 3'd2, 32'h0);
        rd_check("R1 pmask", 3'd3, 32'h7FF);
        rd_check("R1 rmask", 3'd4, 32'h3FFF);
        rd_check("R1 enable", 3'd5, 32'h0);
        rd_check("R1 route", 3'd6, 32'h0);
        evt(11'h7FF, 14'h3FFF, 16'h0BAD, 64'h55);
        rd_check("R1 no capture after reset", 3'd0, 32'h0);
    endtask

    task automatic t_regmap();
        wr(3'd3, 32'hFFFF_F000);
        rd_check("R2 pmask low bits only", 3'd3, 32'h0);
        wr(3'd3, 32'hFFFF_FFFF);
        rd_check("R2 pmask width", 3'd3, 32'h7FF);
        wr(3'd4, 32'hFFFF_FFFF);
        rd_check("R2 rmask width", 3'd4, 32'h3FFF);
        wr(3'd5, 32'hFFFF_FFFA);
        rd_check("R2 enable width", 3'd5, 32'h2);
        wr(3'd6, 32'hFFFF_FFFE);
        rd_check("R2 route bit0", 3'd6, 32'h0);
        rd_check("R2 unmapped addr", 3'd7, 32'h0);
        configure_open();
    endtask

    task automatic t_capture();
        evt(11'h001, 14'h0001, 16'h1234, 64'h0123_4567_89AB_CDEF);
        rd_check("R3 status", 3'd0, 32'h0001_1234);
        rd_check("R3 ts_lo", 3'd1, 32'h89AB_CDEF);
        rd_check("R3 ts_hi", 3'd2, 32'h0123_4567);
    endtask

    task automatic t_ignore_when_full();
        evt(11'h7FF, 14'h3FFF, 16'hBEEF, 64'hFFFF_0000_1111_2222);
        rd_check("R4 status kept", 3'd0, 32'h0001_1234);
        rd_check("R4 ts_lo kept", 3'd1, 32'h89AB_CDEF);
        rd_check("R4 ts_hi kept", 3'd2, 32'h0123_4567);
    endtask

    task automatic t_ack();
        wr(3'd0, 32'hFFFE_FFFF);
        rd_check("R5 write 0 to bit16 no effect", 3'd0, 32'h0001_1234);
        wr(3'd0, 32'h0001_0000);
        rd_check("R5 ack clears valid", 3'd0, 32'h0000_1234);
        rd_check("R5 ts kept after ack", 3'd1, 32'h89AB_CDEF);
        evt(11'h002, 14'h0100, 16'h0042, 64'h0000_0007_0000_0009);
        rd_check("R5 re-armed capture", 3'd0, 32'h0001_0042);
        rd_check("R5 re-armed ts_hi", 3'd2, 32'h0000_0007);
        wr(3'd0, 32'h0001_0000);
    endtask

    task automatic t_masks();
        wr(3'd3, 32'h7FE);
        evt(11'h7FE, 14'h0001, 16'h0001, 64'h10);
        rd_check("R6 param only on masked bits", 3'd0, 32'h0000_0042);
        evt(11'h003, 14'h0001, 16'h0002, 64'h20);
        rd_check("R6 one unmasked param bit", 3'd0, 32'h0001_0002);
        wr(3'd0, 32'h0001_0000);
        wr(3'd3, 32'h0);
        wr(3'd4, 32'h3FFF);
        evt(11'h7FF, 14'h3FFF, 16'h0003, 64'h30);
        rd_check("R6 rule mask all ones", 3'd0, 32'h0000_0002);
        wr(3'd4, 32'h0);
        evt(11'h000, 14'h3FFF, 16'h0004, 64'h40);
        rd_check("R6 no param bit set", 3'd0, 32'h0000_0002);
    endtask

    task automatic t_enable();
        wr(3'd5, 32'h3);
        evt(11'h1, 14'h1, 16'h0005, 64'h50);
        rd_check("R7 enable 3 blocks", 3'd0, 32'h0000_0002);
        wr(3'd5, 32'h0);
        evt(11'h1, 14'h1, 16'h0006, 64'h60);
        rd_check("R7 enable 0 blocks", 3'd0, 32'h0000_0002);
        wr(3'd5, 32'h7);
        evt(11'h1, 14'h1, 16'h0007, 64'h70);
        rd_check("R7 enable 7 captures", 3'd0, 32'h0001_0007);
        wr(3'd0, 32'h0001_0000);
    endtask

    task automatic t_route();
        wr(3'd6, 32'h0);
        evt(11'h1, 14'h1, 16'h0008, 64'h80);
        rd_check("R8 route 0 blocks", 3'd0, 32'h0000_0007);
        wr(3'd6, 32'h1);
        evt(11'h1, 14'h1, 16'h0009, 64'h90);
        rd_check("R8 route 1 captures", 3'd0, 32'h0001_0009);
    endtask

    task automatic t_collide_full();
        ack_and_evt(16'h00AA, 64'hAA);
        rd_check("R9 release wins, strobe dropped", 3'd0, 32'h0000_0009);
        rd_check("R9 ts unchanged", 3'd1, 32'h0000_0090);
    endtask

    task automatic t_collide_empty();
        ack_and_evt(16'h00BB, 64'h0000_00BB_0000_00CC);
        rd_check("R10 capture wins", 3'd0, 32'h0001_00BB);
        rd_check("R10 ts_lo", 3'd1, 32'h0000_00CC);
    endtask

    initial begin
        #4_000_000;
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_capture();
        t_ignore_when_full();
        t_ack();
        t_masks();
        t_enable();
        t_route();
        t_collide_full();
        t_collide_empty();
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule